// File: doc/BRIEF.md
# 5B Code-Group Receive Aligner and Decoder

This block sits after the descrambler in a 100 Mb/s receive path. It takes one recovered bit per accepted strobe. It watches the unaligned bit stream for a run of idle ones followed by the start-of-stream pair. When it finds that pair, it fixes the 5-bit code-group boundary and turns every later code-group into a 4-bit nibble for an MII-style receive side.

A frame starts with two preamble nibbles in place of the start pair. The frame closes on the end-of-stream pair or on a run of idle ones. Any departure from idle that does not begin with the start pair is reported as a false carrier. While that condition lasts, the block emits error nibbles and keeps carrier sense asserted. It also bumps a saturating false-carrier counter.

The input side has a valid strobe only and no ready. The block accepts a bit on every cycle that `ser_vld` is high, so the upstream bit source is never stalled. The output is a one-cycle strobe per nibble slot. The consumer must take each strobe as it comes, because no back-pressure is offered. A frame of N code-groups gives at most one strobe per five accepted bits, plus one extra strobe for the second preamble nibble.

Top module: `rx5b_align_dec`

## Requirements
- R1: After reset, `out_vld`, `out_dv`, `out_err`, `carrier` and `fc_count` are all zero.
- R2: Bits are taken first-bit-first. Suppose at least IDLE_RUN (default 10) consecutive ones are followed by the eight remaining bits of the pair 11000 then 10001. Then `carrier` rises, and two strobes with nibble 0101, `out_dv`=1 and `out_err`=0 appear on consecutive cycles. The first of them is visible after the edge that accepts the pair's last bit.
- R3: After the start pair, each group of five bits on that boundary gives one strobe with `out_dv`=1, visible after the edge that accepts the group's last bit. The nibble is the standard 4B/5B lookup, for example 11110→0, 01001→1, 10101→3, 01011→5, 10110→A and 11101→F.
- R4: The pair 01101 then 00111 inside a frame emits no strobe for either group, and `carrier` falls.
- R5: Inside a frame or a false carrier, IDLE_RUN consecutive ones end it and `carrier` falls. Groups completed before that run ends are emitted normally.
- R6: A group inside a frame that is not a data code is emitted with nibble 1110, `out_dv`=1 and `out_err`=1. This includes a group made of five ones. Group 01101 followed by a group other than 00111 emits that following group's decoded nibble with `out_err`=1.
- R7: A zero after an idle run whose pair check fails starts a false carrier. `carrier` rises, and every code-group slot, including the two checked groups, gives a strobe with nibble 1110, `out_dv`=0 and `out_err`=1. This continues until the ending run of R5.
- R8: Each false carrier adds one to `fc_count`. The counter saturates at all ones. A high `fc_clr` clears it on the next edge and takes priority over an increment.
- R9: A start pair that is not preceded by an idle run of IDLE_RUN ones produces no strobe and no carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Descrambled serial bit |
| ser_vld | input | 1 | Bit accept strobe |
| fc_clr | input | 1 | Synchronous clear of the false-carrier counter |
| out_vld | output | 1 | One-cycle strobe per nibble slot |
| out_nib | output | 4 | Received nibble |
| out_dv | output | 1 | Nibble belongs to a valid frame |
| out_err | output | 1 | Receive error for this nibble |
| carrier | output | 1 | Carrier sense |
| fc_count | output | CNT_W | Saturating false-carrier count |

## Verification
A boundary fixed at the wrong offset shows up within one code-group after the preamble: every data strobe then carries a wrong or erroneous nibble. A stuck or miscounted idle-run tracker shows up as a frame that never starts, never ends, or ends early. At the ports this appears as missing strobes, or as carrier left high after the trailing idles. A wrong pair decision shows up on the very strobe that should carry preamble, because the data-valid flag and the nibble flip to the false-carrier pattern, and on the counter.

// File: rtl/rx5b_pkg.sv
package rx5b_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_CHECK = 2'd1,
    ST_DATA  = 2'd2,
    ST_BAD   = 2'd3
  } rx_state_t;

  localparam logic [9:0] SSD_PAIR = 10'b11000_10001;
  localparam logic [4:0] CG_T     = 5'b01101;
  localparam logic [4:0] CG_R     = 5'b00111;
  localparam logic [3:0] NIB_PRE  = 4'b0101;
  localparam logic [3:0] NIB_ERR  = 4'b1110;

  // returns {is_data, nibble}
  function automatic logic [4:0] cg_lookup(input logic [4:0] g);
    logic [4:0] r;
    case (g)
      5'b11110: r = {1'b1, 4'h0};
      5'b01001: r = {1'b1, 4'h1};
      5'b10100: r = {1'b1, 4'h2};
      5'b10101: r = {1'b1, 4'h3};
      5'b01010: r = {1'b1, 4'h4};
      5'b01011: r = {1'b1, 4'h5};
      5'b01110: r = {1'b1, 4'h6};
      5'b01111: r = {1'b1, 4'h7};
      5'b10010: r = {1'b1, 4'h8};
      5'b10011: r = {1'b1, 4'h9};
      5'b10110: r = {1'b1, 4'hA};
      5'b10111: r = {1'b1, 4'hB};
      5'b11010: r = {1'b1, 4'hC};
      5'b11011: r = {1'b1, 4'hD};
      5'b11100: r = {1'b1, 4'hE};
      5'b11101: r = {1'b1, 4'hF};
      default:  r = {1'b0, NIB_ERR};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rx5b_run_cnt.sv
module rx5b_run_cnt #(
  parameter int LIMIT = 10,
  localparam int RUN_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic bit_i,
  output logic armed,
  output logic run_hit
);

  localparam logic [RUN_W-1:0] LIM = RUN_W'(LIMIT);

  logic [RUN_W-1:0] run_q;

  assign armed   = (run_q == LIM);
  assign run_hit = vld && bit_i && (run_q >= LIM - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (vld) begin
      if (!bit_i)          run_q <= '0;
      else if (run_q != LIM) run_q <= run_q + 1'b1;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIM);  // R5
  AST_RUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !bit_i) |=> !armed);  // R9

endmodule

// File: rtl/rx5b_fc_cnt.sv
module rx5b_fc_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                      count <= '0;
    else if (clr)                    count <= '0;
    else if (inc && (count != '1))   count <= count + ONE;
  end

  AST_FC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));  // R8
  AST_FC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1 && !clr) |=> (count == '1));  // R8
  AST_FC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((count == $past(count)) || (count == $past(count) + ONE)));  // R8

endmodule

// File: rtl/rx5b_align_dec.sv
module rx5b_align_dec
  import rx5b_pkg::*;
#(
  parameter int IDLE_RUN = 10,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_bit,
  input  logic             ser_vld,
  input  logic             fc_clr,
  output logic             out_vld,
  output logic [3:0]       out_nib,
  output logic             out_dv,
  output logic             out_err,
  output logic             carrier,
  output logic [CNT_W-1:0] fc_count
);

  localparam int PH_W = 4;
  localparam int CHK_BITS = 8;  // bits of the pair still unseen at the first zero
  localparam logic [PH_W-1:0] PH_CHK_LAST = PH_W'(CHK_BITS - 1);
  localparam logic [PH_W-1:0] PH_GRP_LAST = PH_W'(4);

  rx_state_t       state;
  logic [8:0]      sr;
  logic [9:0]      sr_nx;
  logic [PH_W-1:0] phase;
  logic            t_hold;
  logic            pend_vld, pend_dv, pend_err;
  logic [3:0]      pend_nib;
  logic            armed, run_hit, fc_inc;
  logic [4:0]      grp, lut;
  logic            chk_done, grp_done, pair_ok;

  assign sr_nx    = {sr, ser_bit};
  assign grp      = sr_nx[4:0];
  assign lut      = cg_lookup(grp);
  assign pair_ok  = (sr_nx == SSD_PAIR);
  assign chk_done = ser_vld && (state == ST_CHECK) && (phase == PH_CHK_LAST);
  assign grp_done = ser_vld && (phase == PH_GRP_LAST) &&
                    ((state == ST_DATA) || (state == ST_BAD));
  assign fc_inc   = chk_done && !pair_ok;

  rx5b_run_cnt #(.LIMIT(IDLE_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .vld(ser_vld), .bit_i(ser_bit),
    .armed(armed), .run_hit(run_hit)
  );

  rx5b_fc_cnt #(.W(CNT_W)) u_fc (
    .clk(clk), .rst_n(rst_n), .clr(fc_clr), .inc(fc_inc), .count(fc_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      sr       <= '0;
      phase    <= '0;
      t_hold   <= 1'b0;
      carrier  <= 1'b0;
      out_vld  <= 1'b0;
      out_nib  <= '0;
      out_dv   <= 1'b0;
      out_err  <= 1'b0;
      pend_vld <= 1'b0;
      pend_nib <= '0;
      pend_dv  <= 1'b0;
      pend_err <= 1'b0;
    end else begin
      out_vld  <= pend_vld;
      out_nib  <= pend_vld ? pend_nib : 4'h0;
      out_dv   <= pend_vld && pend_dv;
      out_err  <= pend_vld && pend_err;
      pend_vld <= 1'b0;
      if (ser_vld) sr <= sr_nx[8:0];

      case (state)
        ST_HUNT: begin
          if (ser_vld && !ser_bit && armed) begin
            state <= ST_CHECK;
            phase <= PH_W'(1);
          end
        end
        ST_CHECK: begin
          if (ser_vld) begin
            phase <= phase + 1'b1;
            if (chk_done) begin
              phase    <= '0;
              carrier  <= 1'b1;
              state    <= pair_ok ? ST_DATA : ST_BAD;
              out_vld  <= 1'b1;
              out_nib  <= pair_ok ? NIB_PRE : NIB_ERR;
              out_dv   <= pair_ok;
              out_err  <= !pair_ok;
              pend_vld <= 1'b1;
              pend_nib <= pair_ok ? NIB_PRE : NIB_ERR;
              pend_dv  <= pair_ok;
              pend_err <= !pair_ok;
            end
          end
        end
        ST_DATA: begin
          if (ser_vld) begin
            phase <= phase + 1'b1;
            if (run_hit) begin
              state   <= ST_HUNT;
              carrier <= 1'b0;
              phase   <= '0;
              t_hold  <= 1'b0;
            end else if (grp_done) begin
              phase <= '0;
              if (t_hold) begin
                t_hold <= 1'b0;
                if (grp == CG_R) begin
                  state   <= ST_HUNT;
                  carrier <= 1'b0;
                end else begin
                  out_vld <= 1'b1;
                  out_nib <= lut[3:0];
                  out_dv  <= 1'b1;
                  out_err <= 1'b1;
                end
              end else if (grp == CG_T) begin
                t_hold <= 1'b1;
              end else begin
                out_vld <= 1'b1;
                out_nib <= lut[3:0];
                out_dv  <= 1'b1;
                out_err <= !lut[4];
              end
            end
          end
        end
        ST_BAD: begin
          if (ser_vld) begin
            phase <= phase + 1'b1;
            if (run_hit) begin
              state   <= ST_HUNT;
              carrier <= 1'b0;
              phase   <= '0;
            end else if (grp_done) begin
              phase   <= '0;
              out_vld <= 1'b1;
              out_nib <= NIB_ERR;
              out_dv  <= 1'b0;
              out_err <= 1'b1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  AST_OUT_IN_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> carrier);  // R2
  AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(carrier) && out_dv) |-> (out_nib == NIB_PRE && !out_err));  // R2
  AST_FALSE_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_dv) |-> (out_err && out_nib == NIB_ERR));  // R7
  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |-> !carrier);  // R4
  AST_FC_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_inc && !fc_clr && fc_count != '1) |=> (fc_count != $past(fc_count)));  // R8
  AST_PEND_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |-> !grp_done);  // R3

endmodule

// File: tb/sim_rx5b_align_dec.sv
module sim_rx5b_align_dec;

  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_bit = 1'b0;
  logic          ser_vld = 1'b0;
  logic          fc_clr = 1'b0;
  logic          out_vld, out_dv, out_err, carrier;
  logic [3:0]    out_nib;
  logic [CW-1:0] fc_count;

  int n_chk = 0;
  int n_bad = 0;
  int idx = 0;
  logic [3:0] lg_nib [256];
  logic       lg_dv  [256];
  logic       lg_err [256];
  logic       lg_crs [256];

  always #10 clk = ~clk;

  rx5b_align_dec #(.IDLE_RUN(10), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_vld(ser_vld),
    .fc_clr(fc_clr), .out_vld(out_vld), .out_nib(out_nib), .out_dv(out_dv),
    .out_err(out_err), .carrier(carrier), .fc_count(fc_count)
  );

  always @(negedge clk) begin
    if (rst_n && out_vld && idx < 256) begin
      lg_nib[idx] = out_nib;
      lg_dv[idx]  = out_dv;
      lg_err[idx] = out_err;
      lg_crs[idx] = carrier;
      idx = idx + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int k, input logic [3:0] nib,
                         input logic dv, input logic err);
    chk({req, " nibble"}, int'(lg_nib[k]), int'(nib));
    chk({req, " dv"},     int'(lg_dv[k]),  int'(dv));
    chk({req, " err"},    int'(lg_err[k]), int'(err));
    chk({req, " crs"},    int'(lg_crs[k]), 1);
  endtask

  task automatic put_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk);
      ser_bit = g[i];
      ser_vld = 1'b1;
    end
  endtask

  task automatic put_idle(input int n);
    for (int i = 0; i < n; i++) put_grp(5'b11111);
  endtask

  task automatic settle();
    @(negedge clk);
    ser_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 out_vld", int'(out_vld), 0);
    chk("R1 carrier", int'(carrier), 0);
    chk("R1 out_dv",  int'(out_dv), 0);
    chk("R1 out_err", int'(out_err), 0);
    chk("R1 fc_count", int'(fc_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_no_idle();
    int b = idx;
    put_grp(5'b11000); put_grp(5'b10001);
    put_grp(5'b01011); put_grp(5'b10100);
    settle();
    chk("R9 strobes", idx - b, 0);
    chk("R9 carrier", int'(carrier), 0);
  endtask

  task automatic t_good_frame();
    int b = idx;
    put_idle(4);
    put_grp(5'b11000); put_grp(5'b10001);
    put_grp(5'b01011); put_grp(5'b10110);
    put_grp(5'b11110); put_grp(5'b11101);
    put_grp(5'b01101); put_grp(5'b00111);
    put_idle(3);
    settle();
    chk("R4 strobe count", idx - b, 6);
    chk_out("R2 pre0", b + 0, 4'h5, 1'b1, 1'b0);
    chk_out("R2 pre1", b + 1, 4'h5, 1'b1, 1'b0);
    chk_out("R3 d5",   b + 2, 4'h5, 1'b1, 1'b0);
    chk_out("R3 dA",   b + 3, 4'hA, 1'b1, 1'b0);
    chk_out("R3 d0",   b + 4, 4'h0, 1'b1, 1'b0);
    chk_out("R3 dF",   b + 5, 4'hF, 1'b1, 1'b0);
    chk("R4 carrier low", int'(carrier), 0);
    chk("R4 fc_count", int'(fc_count), 0);
  endtask

  task automatic t_idle_end();
    int b = idx;
    put_idle(4);
    put_grp(5'b11000); put_grp(5'b10001);
    put_grp(5'b10101);
    put_idle(3);
    settle();
    chk("R5 strobe count", idx - b, 4);
    chk_out("R5 d3", b + 2, 4'h3, 1'b1, 1'b0);
    chk_out("R6 idle in frame", b + 3, 4'hE, 1'b1, 1'b1);
    chk("R5 carrier low", int'(carrier), 0);
  endtask

  task automatic t_bad_codes();
    int b = idx;
    put_idle(4);
    put_grp(5'b11000); put_grp(5'b10001);
    put_grp(5'b00000);
    put_grp(5'b01101); put_grp(5'b01001);
    put_grp(5'b01101); put_grp(5'b00111);
    put_idle(3);
    settle();
    chk("R6 strobe count", idx - b, 4);
    chk_out("R6 invalid", b + 2, 4'hE, 1'b1, 1'b1);
    chk_out("R6 T not R", b + 3, 4'h1, 1'b1, 1'b1);
    chk("R6 carrier low", int'(carrier), 0);
  endtask

  task automatic bad_start();
    put_idle(4);
    put_grp(5'b10101); put_grp(5'b01001);
    put_idle(3);
    settle();
  endtask

  task automatic t_false_carrier();
    int b = idx;
    bad_start();
    chk("R7 strobe count", idx - b, 3);
    for (int k = 0; k < 3; k++) chk_out("R7 err slot", b + k, 4'hE, 1'b0, 1'b1);
    chk("R7 carrier low", int'(carrier), 0);
    chk("R8 count one", int'(fc_count), 1);
  endtask

  task automatic t_counter();
    for (int k = 0; k < 7; k++) bad_start();
    chk("R8 saturate", int'(fc_count), 7);
    @(negedge clk); fc_clr = 1'b1;
    @(negedge clk); fc_clr = 1'b0;
    chk("R8 clear", int'(fc_count), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_idle();
    t_good_frame();
    t_idle_end();
    t_bad_codes();
    t_false_carrier();
    t_counter();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule